// File: doc/BRIEF.md
# RTC Indexed Control and Storage Register File

This block is the host-facing register file of a real-time clock. A byte-wide host bus reaches it through two ports: an index port whose written value selects one register, and a data port that reads or writes the selected register. The file holds `NUM_REGS` bytes, either 64 or 128. Four of the addresses are control registers with their own access rules. All other addresses are plain storage bytes.

The timekeeping, rate generation and alarm comparison logic sit outside this block. That logic reads the two writable control registers through dedicated output ports. It reports events through three one-cycle strobes: periodic tick, alarm match and update done. The block collects those events in the interrupt flag register and drives a level interrupt request from that register's summary bit.

Two resets are provided. `por_n` loads the power-on contents. `rst_n` is the system reset, which touches only the index, some enable bits and the flag register.

Top module: `rtc_regfile_top`

## Requirements
- R1: A write to the index port (`io_sel`=0) keeps only the low log2(`NUM_REGS`) bits of the value: 7 bits with 128 registers, 6 bits with 64.
- R2: A data write to address 0x0A stores the value with bit 7 forced to 0.
- R3: A data write to address 0x0B stores bit 3 as 0. When bit 7 of the written value is 1, bit 4 is stored as 0 as well. The other bits are stored as written.
- R4: A data read (`io_rd`=1, `io_sel`=1) of address 0x0C presents the current flag value on `io_rdata`. On the next clock edge the register becomes 0x00 and `irq` falls.
- R5: Data writes to addresses 0x0C and 0x0D leave both registers unchanged.
- R6: While `rst_n` is low at a clock edge, the index becomes 0, bits 6..4 of 0x0B and all of 0x0C become 0, and 0x0A, 0x0D and the storage bytes keep their contents.
- R7: While `por_n` is low at a clock edge, the index and all storage bytes become 0, 0x0A becomes 0x26, 0x0B becomes 0x02, 0x0C becomes 0x00 and 0x0D becomes 0x80.
- R8: Each event strobe has an enable bit in 0x0B and a flag pattern that it ORs into 0x0C. The periodic strobe uses bit 6 and ORs in 0xC0. The alarm strobe uses bit 5 and ORs in 0xA0. The update strobe uses bit 4 and ORs in 0x90. A strobe whose enable bit is 0 has no effect.
- R9: A strobe that arrives in the same cycle as a clearing read of 0x0C survives the clear. The register then holds only that strobe's flag pattern.
- R10: `irq` equals bit 7 of register 0x0C.
- R11: Every other address is a read/write storage byte that returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| rst_n | input | 1 | System reset, active low, synchronous |
| io_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wr | input | 1 | Write strobe for the port chosen by `io_sel` |
| io_rd | input | 1 | Read strobe for the data port |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Contents of the currently indexed register |
| evt_periodic | input | 1 | Periodic tick event strobe |
| evt_alarm | input | 1 | Alarm match event strobe |
| evt_update | input | 1 | Update complete event strobe |
| ctrl_a | output | 8 | Stored contents of register 0x0A |
| ctrl_b | output | 8 | Stored contents of register 0x0B |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds two instances that share one stimulus. One uses the default of 128 registers. The other uses 64 registers, which brings the narrower index mask within reach: an index value above 0x3F must fold onto the lower half in one instance and not in the other. Most control-register rules and the storage behaviour are covered through the 128-register instance. Its whole top address range can be exercised, including aliasing of index values with bit 7 set.

// File: rtl/rtc_regfile_pkg.sv
package rtc_regfile_pkg;

    // Addresses of the control registers within the file
    localparam int unsigned ADR_CTL_A = 32'h0A;
    localparam int unsigned ADR_CTL_B = 32'h0B;
    localparam int unsigned ADR_FLAGS = 32'h0C;
    localparam int unsigned ADR_STAT  = 32'h0D;

    // Power-on contents
    localparam logic [7:0] POR_CTL_A = 8'h26;
    localparam logic [7:0] POR_CTL_B = 8'h02;
    localparam logic [7:0] POR_FLAGS = 8'h00;
    localparam logic [7:0] POR_STAT  = 8'h80;

    // Bits of control register B kept by the system reset
    localparam logic [7:0] CTL_B_RST_KEEP = 8'h8F;

    // Bit positions in control register B
    localparam int unsigned B_FREEZE = 7;
    localparam int unsigned B_EN_PER = 6;
    localparam int unsigned B_EN_ALM = 5;
    localparam int unsigned B_EN_UPD = 4;
    localparam int unsigned B_SQWAVE = 3;

    // Flag patterns ORed into the flag register per event
    localparam logic [7:0] FLG_PER = 8'hC0;
    localparam logic [7:0] FLG_ALM = 8'hA0;
    localparam logic [7:0] FLG_UPD = 8'h90;

    typedef enum logic [2:0] {
        SEL_STORE,
        SEL_CTL_A,
        SEL_CTL_B,
        SEL_FLAGS,
        SEL_STAT
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] ctl_a;
        logic [7:0] ctl_b;
        logic [7:0] flags;
        logic [7:0] stat;
    } ctl_regs_t;

endpackage

// File: rtl/rtc_index_reg.sv
module rtc_index_reg
    import rtc_regfile_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [ADDR_W-1:0] idx_wdata,
    output logic [ADDR_W-1:0] idx,
    output reg_sel_e          sel
);

    typedef struct packed {
        logic [ADDR_W-1:0] idx;
    } idx_state_t;

    idx_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!rst_n) begin
            st_d.idx = '0;
        end else if (idx_wr) begin
            st_d.idx = idx_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign idx = st_q.idx;

    always_comb begin
        if (st_q.idx == ADDR_W'(ADR_CTL_A)) begin
            sel = SEL_CTL_A;
        end else if (st_q.idx == ADDR_W'(ADR_CTL_B)) begin
            sel = SEL_CTL_B;
        end else if (st_q.idx == ADDR_W'(ADR_FLAGS)) begin
            sel = SEL_FLAGS;
        end else if (st_q.idx == ADDR_W'(ADR_STAT)) begin
            sel = SEL_STAT;
        end else begin
            sel = SEL_STORE;
        end
    end

    // R1: an index write loads exactly the truncated value
    p_idx_load_r1: assert property (@(posedge clk) disable iff (!por_n)
        (idx_wr && rst_n) |=> (idx == $past(idx_wdata)));

    // R6: system reset returns the index to zero
    p_idx_reset_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n) |=> (idx == '0));

endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
    import rtc_regfile_pkg::*;
(
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  reg_sel_e   sel,
    input  logic [7:0] wdata,
    input  logic       evt_periodic,
    input  logic       evt_alarm,
    input  logic       evt_update,
    output ctl_regs_t  regs,
    output logic       irq
);

    ctl_regs_t  st_d, st_q;
    logic [7:0] set_bits;
    logic [7:0] b_wr_val;
    logic       flag_rd;

    assign flag_rd = dat_rd && (sel == SEL_FLAGS);

    always_comb begin
        set_bits = '0;
        if (evt_periodic && st_q.ctl_b[B_EN_PER]) set_bits = set_bits | FLG_PER;
        if (evt_alarm    && st_q.ctl_b[B_EN_ALM]) set_bits = set_bits | FLG_ALM;
        if (evt_update   && st_q.ctl_b[B_EN_UPD]) set_bits = set_bits | FLG_UPD;
    end

    always_comb begin
        b_wr_val           = wdata;
        b_wr_val[B_SQWAVE] = 1'b0;
        if (wdata[B_FREEZE]) begin
            b_wr_val[B_EN_UPD] = 1'b0;
        end
    end

    always_comb begin
        st_d = st_q;
        if (dat_wr) begin
            case (sel)
                SEL_CTL_A: st_d.ctl_a = {1'b0, wdata[6:0]};
                SEL_CTL_B: st_d.ctl_b = b_wr_val;
                default:   ;
            endcase
        end
        if (flag_rd) begin
            st_d.flags = set_bits;
        end else begin
            st_d.flags = st_q.flags | set_bits;
        end
        if (!rst_n) begin
            st_d.ctl_b = st_q.ctl_b & CTL_B_RST_KEEP;
            st_d.flags = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            st_q <= '{ctl_a: POR_CTL_A, ctl_b: POR_CTL_B,
                      flags: POR_FLAGS, stat: POR_STAT};
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q;
    assign irq  = st_q.flags[7];

    // R2: top bit of register A is never stored from the host
    p_ctl_a_write_r2: assert property (@(posedge clk) disable iff (!por_n)
        (dat_wr && sel == SEL_CTL_A && rst_n) |=>
        (regs.ctl_a == {1'b0, $past(wdata[6:0])}));

    // R3: square-wave bit cleared, freeze clears update enable
    p_ctl_b_write_r3: assert property (@(posedge clk) disable iff (!por_n)
        (dat_wr && sel == SEL_CTL_B && rst_n) |=>
        (!regs.ctl_b[B_SQWAVE] && !(regs.ctl_b[B_FREEZE] && regs.ctl_b[B_EN_UPD])));

    // R4: a clearing read with no event leaves the flags empty
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!por_n)
        (flag_rd && !evt_periodic && !evt_alarm && !evt_update) |=>
        (regs.flags == 8'h00 && !irq));

    // R5: host writes do not alter the read-only registers
    p_stat_ro_r5: assert property (@(posedge clk) disable iff (!por_n)
        (dat_wr && sel == SEL_STAT) |=> $stable(regs.stat));

    p_flags_ro_r5: assert property (@(posedge clk) disable iff (!por_n)
        (dat_wr && sel == SEL_FLAGS && !dat_rd && rst_n &&
         !evt_periodic && !evt_alarm && !evt_update) |=> $stable(regs.flags));

    // R6: system reset clears enables 6..4 and the flags
    p_sys_reset_r6: assert property (@(posedge clk) disable iff (!por_n)
        (!rst_n) |=> (regs.flags == 8'h00 && regs.ctl_b[6:4] == 3'b000));

    // R8: an enabled update event raises the request
    p_update_irq_r8: assert property (@(posedge clk) disable iff (!por_n)
        (evt_update && regs.ctl_b[B_EN_UPD] && rst_n) |=> irq);

    // R9: an event coinciding with a clearing read is kept
    p_set_survives_r9: assert property (@(posedge clk) disable iff (!por_n)
        (flag_rd && evt_periodic && regs.ctl_b[B_EN_PER] && rst_n) |=>
        (regs.flags[7] && regs.flags[6]));

endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
    parameter int unsigned NUM_REGS = 128,
    parameter int unsigned ADDR_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    logic [7:0] mem_d [NUM_REGS];
    logic [7:0] mem_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_byte
        always_comb begin
            if (wr_en && addr == ADDR_W'(g)) begin
                mem_d[g] = wdata;
            end else begin
                mem_d[g] = mem_q[g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!por_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                mem_q[i] <= '0;
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[addr];

    // R11: a written byte reads back from the addressed location
    p_store_write_r11: assert property (@(posedge clk) disable iff (!por_n)
        wr_en |=> (mem_q[$past(addr)] == $past(wdata)));

endmodule

// File: rtl/rtc_regfile_top.sv
module rtc_regfile_top
    import rtc_regfile_pkg::*;
#(
    parameter int unsigned NUM_REGS = 128
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic       rst_n,
    input  logic       io_sel,
    input  logic       io_wr,
    input  logic       io_rd,
    input  logic [7:0] io_wdata,
    output logic [7:0] io_rdata,
    input  logic       evt_periodic,
    input  logic       evt_alarm,
    input  logic       evt_update,
    output logic [7:0] ctrl_a,
    output logic [7:0] ctrl_b,
    output logic       irq
);

    localparam int unsigned ADDR_W = $clog2(NUM_REGS);

    logic              idx_wr;
    logic              dat_wr;
    logic              dat_rd;
    logic [ADDR_W-1:0] idx;
    reg_sel_e          sel;
    ctl_regs_t         regs;
    logic [7:0]        store_rdata;

    assign idx_wr = io_wr && !io_sel;
    assign dat_wr = io_wr && io_sel;
    assign dat_rd = io_rd && io_sel;

    rtc_index_reg #(
        .ADDR_W (ADDR_W)
    ) u_index (
        .clk       (clk),
        .por_n     (por_n),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_wdata (io_wdata[ADDR_W-1:0]),
        .idx       (idx),
        .sel       (sel)
    );

    rtc_ctrl_regs u_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .rst_n        (rst_n),
        .dat_wr       (dat_wr),
        .dat_rd       (dat_rd),
        .sel          (sel),
        .wdata        (io_wdata),
        .evt_periodic (evt_periodic),
        .evt_alarm    (evt_alarm),
        .evt_update   (evt_update),
        .regs         (regs),
        .irq          (irq)
    );

    rtc_byte_store #(
        .NUM_REGS (NUM_REGS),
        .ADDR_W   (ADDR_W)
    ) u_store (
        .clk   (clk),
        .por_n (por_n),
        .wr_en (dat_wr && sel == SEL_STORE),
        .addr  (idx),
        .wdata (io_wdata),
        .rdata (store_rdata)
    );

    always_comb begin
        case (sel)
            SEL_CTL_A: io_rdata = regs.ctl_a;
            SEL_CTL_B: io_rdata = regs.ctl_b;
            SEL_FLAGS: io_rdata = regs.flags;
            SEL_STAT:  io_rdata = regs.stat;
            default:   io_rdata = store_rdata;
        endcase
    end

    assign ctrl_a = regs.ctl_a;
    assign ctrl_b = regs.ctl_b;

    // R10: the request level matches the flag summary bit seen by the host
    p_irq_flag_r10: assert property (@(posedge clk) disable iff (!por_n)
        (sel == SEL_FLAGS) |-> (io_rdata[7] == irq));

endmodule

// File: tb/rtc_regfile_top_tb.sv
module rtc_regfile_top_tb;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       rst_n = 1'b1;
    logic       io_sel = 1'b0;
    logic       io_wr = 1'b0;
    logic       io_rd = 1'b0;
    logic [7:0] io_wdata = 8'h00;
    logic       evt_periodic = 1'b0;
    logic       evt_alarm = 1'b0;
    logic       evt_update = 1'b0;
    logic [7:0] io_rdata, io_rdata64;
    logic [7:0] ctrl_a, ctrl_b, ctrl_a64, ctrl_b64;
    logic       irq, irq64;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rtc_regfile_top u_dut (
        .clk (clk), .por_n (por_n), .rst_n (rst_n),
        .io_sel (io_sel), .io_wr (io_wr), .io_rd (io_rd),
        .io_wdata (io_wdata), .io_rdata (io_rdata),
        .evt_periodic (evt_periodic), .evt_alarm (evt_alarm), .evt_update (evt_update),
        .ctrl_a (ctrl_a), .ctrl_b (ctrl_b), .irq (irq)
    );

    rtc_regfile_top #(.NUM_REGS(64)) u_dut64 (
        .clk (clk), .por_n (por_n), .rst_n (rst_n),
        .io_sel (io_sel), .io_wr (io_wr), .io_rd (io_rd),
        .io_wdata (io_wdata), .io_rdata (io_rdata64),
        .evt_periodic (evt_periodic), .evt_alarm (evt_alarm), .evt_update (evt_update),
        .ctrl_a (ctrl_a64), .ctrl_b (ctrl_b64), .irq (irq64)
    );

    // Vector: {read, port, write data, expected read data, requirement number}
    localparam int NVEC = 40;
    localparam logic [21:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h0A, 8'h00, 4'd2},   // R2
        {1'b0, 1'b1, 8'hFF, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h7F, 4'd2},
        {1'b0, 1'b1, 8'h26, 8'h00, 4'd2},
        {1'b1, 1'b1, 8'h00, 8'h26, 4'd2},
        {1'b0, 1'b0, 8'h0B, 8'h00, 4'd3},   // R3
        {1'b0, 1'b1, 8'hFF, 8'h00, 4'd3},
        {1'b1, 1'b1, 8'h00, 8'hE7, 4'd3},
        {1'b0, 1'b1, 8'h1A, 8'h00, 4'd3},
        {1'b1, 1'b1, 8'h00, 8'h12, 4'd3},
        {1'b0, 1'b1, 8'h0E, 8'h00, 4'd3},
        {1'b1, 1'b1, 8'h00, 8'h06, 4'd3},
        {1'b0, 1'b1, 8'h02, 8'h00, 4'd3},
        {1'b1, 1'b1, 8'h00, 8'h02, 4'd3},
        {1'b0, 1'b0, 8'h0D, 8'h00, 4'd5},   // R5
        {1'b0, 1'b1, 8'h00, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h80, 4'd5},
        {1'b0, 1'b0, 8'h0C, 8'h00, 4'd5},
        {1'b0, 1'b1, 8'hFF, 8'h00, 4'd5},
        {1'b1, 1'b1, 8'h00, 8'h00, 4'd5},
        {1'b0, 1'b0, 8'h40, 8'h00, 4'd11},  // R11
        {1'b0, 1'b1, 8'hA5, 8'h00, 4'd11},
        {1'b0, 1'b0, 8'h41, 8'h00, 4'd11},
        {1'b0, 1'b1, 8'h5A, 8'h00, 4'd11},
        {1'b0, 1'b0, 8'h40, 8'h00, 4'd11},
        {1'b1, 1'b1, 8'h00, 8'hA5, 4'd11},
        {1'b0, 1'b0, 8'h41, 8'h00, 4'd11},
        {1'b1, 1'b1, 8'h00, 8'h5A, 4'd11},
        {1'b0, 1'b0, 8'h20, 8'h00, 4'd1},   // R1: 0xA0 aliases 0x20
        {1'b0, 1'b1, 8'h11, 8'h00, 4'd1},
        {1'b0, 1'b0, 8'hA0, 8'h00, 4'd1},
        {1'b0, 1'b1, 8'h22, 8'h00, 4'd1},
        {1'b0, 1'b0, 8'h20, 8'h00, 4'd1},
        {1'b1, 1'b1, 8'h00, 8'h22, 4'd1},
        {1'b0, 1'b0, 8'h7F, 8'h00, 4'd11},
        {1'b0, 1'b1, 8'hC3, 8'h00, 4'd11},
        {1'b1, 1'b1, 8'h00, 8'hC3, 4'd11},
        {1'b0, 1'b0, 8'h00, 8'h00, 4'd11},
        {1'b0, 1'b1, 8'h59, 8'h00, 4'd11},
        {1'b1, 1'b1, 8'h00, 8'h59, 4'd11}
    };

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr_port(input logic s, input logic [7:0] v);
        @(negedge clk);
        io_sel = s; io_wr = 1'b1; io_wdata = v;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_check(input logic [7:0] exp, input string req);
        @(negedge clk);
        io_sel = 1'b1; io_rd = 1'b1;
        #1;
        check8(io_rdata, exp, req);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic set_reg(input logic [7:0] adr, input logic [7:0] v);
        wr_port(1'b0, adr);
        wr_port(1'b1, v);
    endtask

    task automatic pulse(input int kind);
        @(negedge clk);
        evt_periodic = (kind == 0); evt_alarm = (kind == 1); evt_update = (kind == 2);
        @(negedge clk);
        evt_periodic = 1'b0; evt_alarm = 1'b0; evt_update = 1'b0;
    endtask

    task automatic check_irq(input logic exp, input string req);
        #1;
        check8({7'b0, irq}, {7'b0, exp}, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;

        // R7: power-on contents
        rd_check(8'h00, "R7 index/storage");
        wr_port(1'b0, 8'h0A); rd_check(8'h26, "R7 reg A");
        wr_port(1'b0, 8'h0B); rd_check(8'h02, "R7 reg B");
        wr_port(1'b0, 8'h0C); rd_check(8'h00, "R7 flags");
        wr_port(1'b0, 8'h0D); rd_check(8'h80, "R7 reg D");
        check_irq(1'b0, "R7 irq");

        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][21]) begin
                rd_check(VEC[i][11:4], $sformatf("R%0d vector %0d", VEC[i][3:0], i));
            end else begin
                wr_port(VEC[i][20], VEC[i][19:12]);
            end
        end

        // R1: 64-register instance folds index 0xFE onto 0x3E
        wr_port(1'b0, 8'hFE);
        wr_port(1'b1, 8'h3C);
        wr_port(1'b0, 8'h3E);
        #1;
        check8(io_rdata64, 8'h3C, "R1 six-bit index");
        check8(io_rdata, 8'h00, "R1 seven-bit index");

        // R8 and R10: enabled periodic event
        set_reg(8'h0B, 8'h42);
        check8(ctrl_b, 8'h42, "R3 ctrl_b port");
        pulse(0);
        check_irq(1'b1, "R10 irq after periodic");
        wr_port(1'b0, 8'h0C);
        rd_check(8'hC0, "R8 periodic flags");
        check_irq(1'b0, "R4 irq after clearing read");
        rd_check(8'h00, "R4 flags after clearing read");

        // R8: disabled events ignored
        set_reg(8'h0B, 8'h02);
        pulse(0); pulse(1); pulse(2);
        check_irq(1'b0, "R8 disabled irq");
        wr_port(1'b0, 8'h0C);
        rd_check(8'h00, "R8 disabled flags");

        // R8: alarm and update combine
        set_reg(8'h0B, 8'h32);
        pulse(1); pulse(2);
        wr_port(1'b0, 8'h0C);
        rd_check(8'hB0, "R8 alarm+update flags");

        // R9: event during clearing read survives
        set_reg(8'h0B, 8'h62);
        pulse(0);
        wr_port(1'b0, 8'h0C);
        @(negedge clk);
        io_sel = 1'b1; io_rd = 1'b1; evt_alarm = 1'b1;
        #1;
        check8(io_rdata, 8'hC0, "R9 value seen by read");
        @(negedge clk);
        io_rd = 1'b0; evt_alarm = 1'b0;
        check_irq(1'b1, "R9 irq kept");
        rd_check(8'hA0, "R9 surviving flags");

        // R6: system reset
        set_reg(8'h0B, 8'h72);
        set_reg(8'h0A, 8'h2F);
        check8(ctrl_a, 8'h2F, "R2 ctrl_a port");
        pulse(0);
        wr_port(1'b0, 8'h0B);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_check(8'h59, "R6 index cleared");
        wr_port(1'b0, 8'h0B); rd_check(8'h02, "R6 reg B enables");
        wr_port(1'b0, 8'h0A); rd_check(8'h2F, "R6 reg A kept");
        wr_port(1'b0, 8'h0C); rd_check(8'h00, "R6 flags cleared");
        check_irq(1'b0, "R6 irq");
        wr_port(1'b0, 8'h0D); rd_check(8'h80, "R6 reg D kept");
        wr_port(1'b0, 8'h40); rd_check(8'hA5, "R6 storage kept");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule